// File: doc/BRIEF.md
# Shared Scratchpad Memory with Atomic Operations

This block is a 4096-word by 32-bit on-chip scratchpad shared by several independent requesters. Each requester presents a command made of an opcode, a 12-bit word address, a burst length, a return flag, a response tag and a 32-bit data word. A round-robin arbiter picks one command at a time and runs it to the end before it looks at the ports again. The storage is one inferred single-port RAM. Every write stores a full 32-bit word. There are no byte enables.

Plain reads and writes move 1 to 16 consecutive words. During a write burst the block asks the owning port for each data word with a take strobe and a beat index. Read data comes back in order, one word per cycle, and the final word is marked.

Seven single-word atomic operations read the word, modify it and write it back with no other access in between. Each can send the old value back to the requester. A done pulse tells the requester that its write or atomic has reached the array.

Top module: `spad_top`

## Requirements
- R1: While reset is held, and until the first request, `req_ack`, `wr_take`, `rsp_valid`, `rsp_last` and `cmd_done` are all zero.
- R2: A write (opcode 1) with length field L stores L+1 words at consecutive addresses. In the k-th cycle after the grant cycle, `wr_take` of the owning port is high with `wr_beat` = k-1, and the word on that port's data input is stored. `cmd_done` of that port pulses for one cycle, L+2 cycles after the grant.
- R3: A read (opcode 0) with length field L returns L+1 words in address order, one per cycle. The first word appears 2 cycles after the grant. `rsp_last` is high only with the final word.
- R4: Burst addresses past word 4095 wrap to word 0.
- R5: Bit-set (opcode 2) ORs the operand into the word. Bit-clear (opcode 3) ANDs the word with the inverted operand.
- R6: Increment (opcode 4) and decrement (opcode 5) change the word by one, modulo 2^32. The operand is ignored.
- R7: Add (opcode 6) and subtract (opcode 7) combine the word with the operand, modulo 2^32, with no saturation.
- R8: Swap (opcode 8) stores the operand.
- R9: An atomic with the return flag set puts the pre-change word on `rsp_data`, with `rsp_last` high, 2 cycles after the grant. With the flag clear it returns nothing. In both cases `cmd_done` pulses 3 cycles after the grant.
- R10: At most one `req_ack` bit is high, and only in a cycle where that port is requesting. After a grant to port p, the search starts at port p+1. No command is acknowledged while another is still running.
- R11: Each response carries the tag of the command it belongs to on `rsp_tag`.
- R12: A read granted after a write to the same address returns the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | NPORT | Command pending, one bit per port |
| req_ack | output | NPORT | Command accepted this cycle, one bit per port |
| req_op | input | 4*NPORT | Opcode per port |
| req_addr | input | 12*NPORT | Start word address per port |
| req_len | input | 4*NPORT | Burst length minus one per port |
| req_ret | input | NPORT | Return old value on atomics, per port |
| req_tag | input | 4*NPORT | Response tag per port |
| req_wdata | input | 32*NPORT | Write word or atomic operand per port |
| wr_take | output | NPORT | Write word consumed this cycle, per port |
| wr_beat | output | 4 | Index of the write word being consumed |
| rsp_valid | output | NPORT | Response word valid, per port |
| rsp_last | output | 1 | Final word of the response |
| rsp_tag | output | 4 | Tag of the responding command |
| rsp_data | output | 32 | Response word |
| cmd_done | output | NPORT | Write or atomic committed, per port |

## Verification
Every result is tied to the cycle in which the grant is seen. Read word k is due 2+k cycles after the grant. An atomic's old value is due 2 cycles after the grant and its done pulse 3 cycles after. A write's done pulse is due L+2 cycles after the grant. A monitor running on the falling edge logs each response, done pulse and take strobe with the cycle count, and the bench compares those logged cycles with the grant cycle plus the latency for each result. A table of atomic operations on one word is chained so that each row's expected old value is the result of the row before.

// File: rtl/spad_pkg.sv
package spad_pkg;

  typedef enum logic [3:0] {
    OP_READ  = 4'd0,
    OP_WRITE = 4'd1,
    OP_BSET  = 4'd2,
    OP_BCLR  = 4'd3,
    OP_INC   = 4'd4,
    OP_DEC   = 4'd5,
    OP_ADD   = 4'd6,
    OP_SUB   = 4'd7,
    OP_SWAP  = 4'd8
  } spad_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BURST,
    ST_RMW_RD,
    ST_RMW_WR
  } spad_st_e;

  function automatic logic is_rmw(input logic [3:0] op);
    return (op >= 4'd2) && (op <= 4'd8);
  endfunction

endpackage

// File: rtl/spad_arb.sv
module spad_arb #(
  parameter int NPORT = 2,
  parameter int IW    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] req,
  input  logic             take,
  output logic [NPORT-1:0] gnt,
  output logic [IW-1:0]    gnt_idx,
  output logic             any
);

  logic [IW-1:0] last_q;

  // search starts one past the last granted port
  always_comb begin
    gnt     = '0;
    gnt_idx = last_q;
    any     = 1'b0;
    for (int k = 1; k <= NPORT; k++) begin
      int c;
      c = int'(last_q) + k;
      if (c >= NPORT) c = c - NPORT;
      if (!any && req[c]) begin
        any     = 1'b1;
        gnt[c]  = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IW'(NPORT - 1);
    end else if (take) begin
      last_q <= gnt_idx;
    end
  end

endmodule

// File: rtl/spad_alu.sv
module spad_alu
  import spad_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] old_word,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] new_word
);

  always_comb begin
    case (op)
      OP_BSET: new_word = old_word | operand;
      OP_BCLR: new_word = old_word & ~operand;
      OP_INC:  new_word = old_word + DW'(1);
      OP_DEC:  new_word = old_word - DW'(1);
      OP_ADD:  new_word = old_word + operand;
      OP_SUB:  new_word = old_word - operand;
      OP_SWAP: new_word = operand;
      default: new_word = old_word;
    endcase
  end

endmodule

// File: rtl/spad_ram.sv
module spad_ram #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read port holds its value through a write cycle
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/spad_top.sv
module spad_top
  import spad_pkg::*;
#(
  parameter int NPORT = 2,
  parameter int AW    = 12,
  parameter int DW    = 32,
  parameter int LW    = 4,
  parameter int TW    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NPORT-1:0]     req_valid,
  output logic [NPORT-1:0]     req_ack,
  input  logic [4*NPORT-1:0]   req_op,
  input  logic [AW*NPORT-1:0]  req_addr,
  input  logic [LW*NPORT-1:0]  req_len,
  input  logic [NPORT-1:0]     req_ret,
  input  logic [TW*NPORT-1:0]  req_tag,
  input  logic [DW*NPORT-1:0]  req_wdata,
  output logic [NPORT-1:0]     wr_take,
  output logic [LW-1:0]        wr_beat,
  output logic [NPORT-1:0]     rsp_valid,
  output logic                 rsp_last,
  output logic [TW-1:0]        rsp_tag,
  output logic [DW-1:0]        rsp_data,
  output logic [NPORT-1:0]     cmd_done
);

  localparam int IW  = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int OPW = 4;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ln = rst_pipe[1];

  spad_st_e      st, st_n;
  logic [OPW-1:0] cmd_op, op_n;
  logic [AW-1:0] cmd_addr, addr_n;
  logic [LW-1:0] cmd_len, len_n, cmd_beat, beat_n;
  logic [TW-1:0] cmd_tag, tag_n;
  logic [IW-1:0] cmd_port, port_n;
  logic          cmd_ret, ret_n;
  logic [DW-1:0] cmd_opnd, opnd_n;
  logic          rd_v, rdv_n, rd_last, rdlast_n;
  logic [IW-1:0] rd_port, rdport_n;
  logic [TW-1:0] rd_tag, rdtag_n;
  logic [NPORT-1:0] done_q, done_n;

  logic [NPORT-1:0] gnt;
  logic [IW-1:0]    gnt_idx;
  logic             any_req, arb_take;
  logic             is_wr;

  logic          ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_rdata, alu_new;

  assign arb_take = (st == ST_IDLE) && any_req;
  assign is_wr    = (cmd_op == OP_WRITE);

  spad_arb #(.NPORT(NPORT), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_ln), .req(req_valid), .take(arb_take),
    .gnt(gnt), .gnt_idx(gnt_idx), .any(any_req)
  );

  spad_alu #(.DW(DW)) u_alu (
    .op(cmd_op), .old_word(ram_rdata), .operand(cmd_opnd), .new_word(alu_new)
  );

  spad_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  always_comb begin
    st_n     = st;
    op_n     = cmd_op;
    addr_n   = cmd_addr;
    len_n    = cmd_len;
    beat_n   = cmd_beat;
    tag_n    = cmd_tag;
    port_n   = cmd_port;
    ret_n    = cmd_ret;
    opnd_n   = cmd_opnd;
    rdv_n    = 1'b0;
    rdlast_n = 1'b0;
    rdport_n = rd_port;
    rdtag_n  = rd_tag;
    done_n   = '0;
    req_ack  = '0;
    wr_take  = '0;
    ram_en   = 1'b0;
    ram_we   = 1'b0;
    ram_addr = cmd_addr;
    ram_wdata = req_wdata[cmd_port*DW +: DW];
    case (st)
      ST_IDLE: begin
        if (any_req) begin
          req_ack = gnt;
          op_n    = req_op[gnt_idx*OPW +: OPW];
          addr_n  = req_addr[gnt_idx*AW +: AW];
          len_n   = req_len[gnt_idx*LW +: LW];
          tag_n   = req_tag[gnt_idx*TW +: TW];
          ret_n   = req_ret[gnt_idx];
          opnd_n  = req_wdata[gnt_idx*DW +: DW];
          port_n  = gnt_idx;
          beat_n  = '0;
          st_n    = is_rmw(op_n) ? ST_RMW_RD : ST_BURST;
        end
      end
      ST_BURST: begin
        ram_en   = 1'b1;
        ram_we   = is_wr;
        ram_addr = cmd_addr + AW'(cmd_beat);
        if (is_wr) begin
          wr_take[cmd_port] = 1'b1;
        end else begin
          rdv_n    = 1'b1;
          rdlast_n = (cmd_beat == cmd_len);
          rdport_n = cmd_port;
          rdtag_n  = cmd_tag;
        end
        if (cmd_beat == cmd_len) begin
          st_n   = ST_IDLE;
          beat_n = '0;
          if (is_wr) done_n[cmd_port] = 1'b1;
        end else begin
          beat_n = cmd_beat + LW'(1);
        end
      end
      ST_RMW_RD: begin
        ram_en   = 1'b1;
        rdv_n    = cmd_ret;
        rdlast_n = cmd_ret;
        rdport_n = cmd_port;
        rdtag_n  = cmd_tag;
        st_n     = ST_RMW_WR;
      end
      ST_RMW_WR: begin
        ram_en    = 1'b1;
        ram_we    = 1'b1;
        ram_wdata = alu_new;
        done_n[cmd_port] = 1'b1;
        st_n      = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      st       <= ST_IDLE;
      cmd_op   <= '0;
      cmd_addr <= '0;
      cmd_len  <= '0;
      cmd_beat <= '0;
      cmd_tag  <= '0;
      cmd_port <= '0;
      cmd_ret  <= 1'b0;
      cmd_opnd <= '0;
      rd_v     <= 1'b0;
      rd_last  <= 1'b0;
      rd_port  <= '0;
      rd_tag   <= '0;
      done_q   <= '0;
    end else begin
      st       <= st_n;
      cmd_beat <= beat_n;
      rd_v     <= rdv_n;
      rd_last  <= rdlast_n;
      rd_port  <= rdport_n;
      rd_tag   <= rdtag_n;
      done_q   <= done_n;
      if (arb_take) begin
        cmd_op   <= op_n;
        cmd_addr <= addr_n;
        cmd_len  <= len_n;
        cmd_tag  <= tag_n;
        cmd_port <= port_n;
        cmd_ret  <= ret_n;
        cmd_opnd <= opnd_n;
      end
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_rsp
    assign rsp_valid[g] = rd_v && (rd_port == IW'(g));
  end

  assign rsp_last = rd_last;
  assign rsp_tag  = rd_tag;
  assign rsp_data = ram_rdata;
  assign cmd_done = done_q;
  assign wr_beat  = cmd_beat;

endmodule

// File: rtl/spad_chk.sv
module spad_chk #(
  parameter int NPORT = 2,
  parameter int LW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPORT-1:0] req_valid,
  input logic [NPORT-1:0] req_ack,
  input logic [NPORT-1:0] wr_take,
  input logic [LW-1:0]    wr_beat,
  input logic [NPORT-1:0] rsp_valid,
  input logic             rsp_last,
  input logic [NPORT-1:0] cmd_done
);

  // R10
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ack));

  // R10
  ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack & ~req_valid) == '0);

  // R10
  ack_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ack) |=> (req_ack == '0));

  // R3
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  // R3
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> (|rsp_valid));

  // R2
  take_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_take) && !((|wr_take) && (|req_ack)));

  // R2
  take_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wr_take) && (|$past(wr_take))) |-> (wr_beat == LW'($past(wr_beat) + 1'b1)));

  // R2
  done_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmd_done) |=> (cmd_done == '0));

  // R9
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_done) && !((|cmd_done) && (|wr_take)));

endmodule

bind spad_top spad_chk #(.NPORT(NPORT), .LW(LW)) u_spad_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
  .wr_take(wr_take), .wr_beat(wr_beat), .rsp_valid(rsp_valid),
  .rsp_last(rsp_last), .cmd_done(cmd_done)
);

// File: tb/spad_top_bench.sv
module spad_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NP-1:0]    req_valid;
  logic [NP-1:0]    req_ack;
  logic [4*NP-1:0]  req_op;
  logic [12*NP-1:0] req_addr;
  logic [4*NP-1:0]  req_len;
  logic [NP-1:0]    req_ret;
  logic [4*NP-1:0]  req_tag;
  logic [32*NP-1:0] req_wdata;
  logic [NP-1:0]    wr_take;
  logic [3:0]       wr_beat;
  logic [NP-1:0]    rsp_valid;
  logic             rsp_last;
  logic [3:0]       rsp_tag;
  logic [31:0]      rsp_data;
  logic [NP-1:0]    cmd_done;

  logic        t_v[NP];
  logic [3:0]  t_op[NP];
  logic [11:0] t_addr[NP];
  logic [3:0]  t_len[NP];
  logic        t_ret[NP];
  logic [3:0]  t_tag[NP];
  logic [31:0] t_seed[NP];

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      req_valid[p]          = t_v[p];
      req_op[p*4 +: 4]      = t_op[p];
      req_addr[p*12 +: 12]  = t_addr[p];
      req_len[p*4 +: 4]     = t_len[p];
      req_ret[p]            = t_ret[p];
      req_tag[p*4 +: 4]     = t_tag[p];
      req_wdata[p*32 +: 32] = t_seed[p] + 32'(wr_beat);
    end
  end

  spad_top u_spad_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
    .req_op(req_op), .req_addr(req_addr), .req_len(req_len), .req_ret(req_ret),
    .req_tag(req_tag), .req_wdata(req_wdata), .wr_take(wr_take), .wr_beat(wr_beat),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_tag(rsp_tag),
    .rsp_data(rsp_data), .cmd_done(cmd_done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // falling-edge log of responses, done pulses and take strobes
  logic [31:0] cap_d[256];
  int          cap_c[256];
  int          cap_p[256];
  logic        cap_l[256];
  logic [3:0]  cap_t[256];
  int          cap_n = 0;
  int          dn_c[64];
  int          dn_p[64];
  int          dn_n = 0;
  int          tk_n[NP];

  initial for (int p = 0; p < NP; p++) tk_n[p] = 0;

  always @(negedge clk) begin
    if ((|rsp_valid) && cap_n < 256) begin
      cap_d[cap_n] = rsp_data;
      cap_c[cap_n] = cyc;
      cap_p[cap_n] = rsp_valid[1] ? 1 : 0;
      cap_l[cap_n] = rsp_last;
      cap_t[cap_n] = rsp_tag;
      cap_n++;
    end
    if ((|cmd_done) && dn_n < 64) begin
      dn_c[dn_n] = cyc;
      dn_p[dn_n] = cmd_done[1] ? 1 : 0;
      dn_n++;
    end
    for (int p = 0; p < NP; p++) if (wr_take[p]) tk_n[p]++;
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic send(input int p, input logic [3:0] op, input logic [11:0] addr,
                      input logic [3:0] len, input logic ret, input logic [3:0] tag,
                      input logic [31:0] seed, output int g);
    @(negedge clk);
    t_op[p] = op; t_addr[p] = addr; t_len[p] = len;
    t_ret[p] = ret; t_tag[p] = tag; t_seed[p] = seed; t_v[p] = 1'b1;
    g = -1;
    for (int w = 0; w < 60 && g < 0; w++) begin
      #1;
      if (req_ack[p]) g = cyc;
      else @(negedge clk);
    end
    @(negedge clk);
    t_v[p] = 1'b0;
  endtask

  task automatic settle();
    repeat (24) @(negedge clk);
  endtask

  function automatic string op_req(input logic [3:0] op);
    case (op)
      4'd2, 4'd3: return "R5";
      4'd4, 4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      default:    return "R8";
    endcase
  endfunction

  // chained atomics on one word: {opcode, operand, expected old value}
  localparam int NROW = 9;
  localparam logic [67:0] ATOM_TAB [NROW] = '{
    {4'd2, 32'h0F00_000F, 32'h0000_00F0},
    {4'd3, 32'h0000_00F0, 32'h0F00_00FF},
    {4'd4, 32'hDEAD_0000, 32'h0F00_000F},
    {4'd6, 32'hF100_0000, 32'h0F00_0010},
    {4'd7, 32'h0000_0011, 32'h0000_0010},
    {4'd4, 32'h0000_0000, 32'hFFFF_FFFF},
    {4'd5, 32'hDEAD_0000, 32'h0000_0000},
    {4'd8, 32'h1234_5678, 32'hFFFF_FFFF},
    {4'd5, 32'h0000_0000, 32'h1234_5678}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int g, b, b0, b1, t0;
    for (int p = 0; p < NP; p++) begin
      t_v[p] = 1'b0; t_op[p] = '0; t_addr[p] = '0; t_len[p] = '0;
      t_ret[p] = 1'b0; t_tag[p] = '0; t_seed[p] = '0;
    end
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk({req_ack, wr_take, rsp_valid, rsp_last, cmd_done} == '0, "R1", "outputs in reset",
        32'({req_ack, wr_take, rsp_valid, rsp_last, cmd_done}), 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk({req_ack, rsp_valid, cmd_done} == '0, "R1", "outputs after reset",
        32'({req_ack, rsp_valid, cmd_done}), 32'h0);

    // R2: 16-word write burst from port 0
    b = cap_n; b0 = dn_n; t0 = tk_n[0];
    send(0, 4'd1, 12'h010, 4'd15, 1'b0, 4'd3, 32'hA000_0000, g);
    settle();
    chk(tk_n[0] - t0 == 16, "R2", "take strobes", 32'(tk_n[0] - t0), 32'd16);
    chk(dn_n - b0 == 1, "R2", "done count", 32'(dn_n - b0), 32'd1);
    chk(dn_c[b0] == g + 17 && dn_p[b0] == 0, "R2", "done cycle", 32'(dn_c[b0] - g), 32'd17);
    chk(cap_n == b, "R2", "no response to write", 32'(cap_n - b), 32'd0);

    // R3 R11 R12: read back from port 1
    b = cap_n;
    send(1, 4'd0, 12'h010, 4'd15, 1'b0, 4'd5, 32'h0, g);
    settle();
    chk(cap_n - b == 16, "R3", "read word count", 32'(cap_n - b), 32'd16);
    for (int k = 0; k < 16; k++) begin
      chk(cap_d[b+k] == 32'hA000_0000 + 32'(k), "R12", "read data", cap_d[b+k],
          32'hA000_0000 + 32'(k));
      chk(cap_c[b+k] == g + 2 + k, "R3", "read timing", 32'(cap_c[b+k] - g), 32'(2 + k));
      chk(cap_l[b+k] == (k == 15), "R3", "last marker", 32'(cap_l[b+k]), 32'(k == 15));
      chk(cap_t[b+k] == 4'd5 && cap_p[b+k] == 1, "R11", "tag and port",
          32'({cap_t[b+k], 4'(cap_p[b+k])}), 32'h51);
    end

    // R4: wrap past the top word
    send(1, 4'd1, 12'hFFE, 4'd3, 1'b0, 4'd1, 32'h0000_00B0, g);
    settle();
    b = cap_n;
    send(0, 4'd0, 12'h000, 4'd1, 1'b0, 4'd2, 32'h0, g);
    settle();
    chk(cap_n - b == 2 && cap_d[b] == 32'hB2 && cap_d[b+1] == 32'hB3, "R4", "low words",
        cap_d[b], 32'hB2);
    b = cap_n;
    send(0, 4'd0, 12'hFFE, 4'd3, 1'b0, 4'd4, 32'h0, g);
    settle();
    for (int k = 0; k < 4; k++)
      chk(cap_d[b+k] == 32'hB0 + 32'(k), "R4", "wrapped read", cap_d[b+k], 32'hB0 + 32'(k));

    // R5..R9: chained atomics on word 0x100
    send(0, 4'd1, 12'h100, 4'd0, 1'b0, 4'd0, 32'h0000_00F0, g);
    settle();
    for (int r = 0; r < NROW; r++) begin
      logic [3:0]  op;
      logic [31:0] opnd, exp_old;
      {op, opnd, exp_old} = ATOM_TAB[r];
      b = cap_n; b1 = dn_n;
      send(r % 2, op, 12'h100, 4'd9, 1'b1, 4'(r), opnd, g);
      settle();
      chk(cap_n - b == 1 && cap_d[b] == exp_old, op_req(op), "old value", cap_d[b], exp_old);
      chk(cap_c[b] == g + 2 && cap_l[b] && cap_t[b] == 4'(r), "R9", "return timing",
          32'(cap_c[b] - g), 32'd2);
      chk(dn_n - b1 == 1 && dn_c[b1] == g + 3 && dn_p[b1] == r % 2, "R9", "atomic done",
          32'(dn_c[b1] - g), 32'd3);
    end

    // R9: no return when the flag is clear; R6 result checked by readback
    b = cap_n; b1 = dn_n;
    send(0, 4'd4, 12'h100, 4'd0, 1'b0, 4'd7, 32'h0, g);
    settle();
    chk(cap_n == b, "R9", "no response without flag", 32'(cap_n - b), 32'd0);
    chk(dn_n - b1 == 1 && dn_c[b1] == g + 3, "R9", "done without flag",
        32'(dn_c[b1] - g), 32'd3);
    b = cap_n;
    send(0, 4'd0, 12'h100, 4'd0, 1'b0, 4'd8, 32'h0, g);
    settle();
    chk(cap_d[b] == 32'h1234_5678, "R6", "final word", cap_d[b], 32'h1234_5678);

    // R10: both ports request at once; port 0 had the last grant
    begin
      int first, second;
      bit got0, got1, drop0, drop1;
      first = -1; second = -1;
      got0 = 0; got1 = 0; drop0 = 0; drop1 = 0;
      b = cap_n;
      @(negedge clk);
      t_op[0] = 4'd0; t_addr[0] = 12'h010; t_len[0] = 4'd3; t_tag[0] = 4'd1; t_v[0] = 1'b1;
      t_op[1] = 4'd0; t_addr[1] = 12'hFFE; t_len[1] = 4'd1; t_tag[1] = 4'd2; t_v[1] = 1'b1;
      for (int w = 0; w < 60 && !(got0 && got1); w++) begin
        if (w > 0) @(negedge clk);
        if (drop0) t_v[0] = 1'b0;
        if (drop1) t_v[1] = 1'b0;
        #1;
        if (req_ack[0] && !got0) begin
          got0 = 1; drop0 = 1;
          if (first < 0) first = 0; else second = 0;
        end
        if (req_ack[1] && !got1) begin
          got1 = 1; drop1 = 1;
          if (first < 0) first = 1; else second = 1;
        end
      end
      @(negedge clk);
      t_v[0] = 1'b0; t_v[1] = 1'b0;
      settle();
      chk(first == 1 && second == 0, "R10", "grant order", 32'(first), 32'd1);
      chk(cap_n - b == 6, "R10", "response count", 32'(cap_n - b), 32'd6);
      for (int k = 0; k < 6; k++)
        chk(cap_p[b+k] == (k < 2 ? 1 : 0), "R10", "no interleave", 32'(cap_p[b+k]),
            32'(k < 2 ? 1 : 0));
      chk(cap_d[b] == 32'hB0 && cap_d[b+2] == 32'hA000_0000, "R11", "data per owner",
          cap_d[b+2], 32'hA000_0000);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule